// File: doc/BRIEF.md
# I2C Serial Clock Phase Generator

This block produces the serial clock of an I2C initiator from the peripheral clock. A 16-bit divisor register holds two independent 8-bit counts, one for the high phase and one for the low phase, so the bus rate and duty cycle can be set separately. The SCL output is open-drain style: the block only ever asks for the line to be pulled low and otherwise releases it.

While the enable input is high the block alternates low and high phases, always starting a period with the low phase. Each phase length is fixed when the phase begins, so a divisor write never disturbs a phase already in progress. A one-cycle strobe marks the first cycle of every low phase and of every high phase, so a byte engine can shift or sample data on the edges. Dropping enable releases the line at once and parks the phase counter at zero.

With a 26 MHz peripheral clock, a high count of 0x1D and a low count of 0x21 give phases of about 1200 ns and 1300 ns, close to a 400 kHz bus.

Top module: `scl_phase_gen`

## Requirements
- R1: A write on the register port loads the 16-bit divisor in the following cycle; bits [15:8] are the high-phase count and bits [7:0] are the low-phase count.
- R2: Each low phase (pull-low request at 1) lasts the low count plus 1 clock cycles.
- R3: Each high phase (line released while enabled) lasts the high count plus 2 clock cycles.
- R4: After reset the divisor is 0x1F1F (32 cycles low, 33 cycles high), the line is released and both strobes are 0.
- R5: When enable is sampled high while idle, the low phase begins in the next cycle, so every period after enable starts low.
- R6: The falling strobe is 1 for exactly the first cycle of each low phase and the rising strobe for exactly the first cycle of each high phase; the two are never 1 together.
- R7: A phase takes its length from the divisor held in the cycle before it starts; a write landing during a phase changes only the phases that start afterwards.
- R8: When enable is sampled low, the line is released in the next cycle with no strobe, and a later enable begins again with a full low phase.
- R9: A count of 0 gives a 1-cycle low phase or a 2-cycle high phase; a count of 0xFF gives 256 or 257 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | 16 | Divisor write value: [15:8] high count, [7:0] low count |
| enable | input | 1 | Run the clock while high |
| scl_pull_low | output | 1 | 1 requests the SCL line be driven low; 0 releases it |
| fall_stb | output | 1 | One-cycle mark on the first cycle of a low phase |
| rise_stb | output | 1 | One-cycle mark on the first cycle of a high phase |

## Verification
The collision of interest is a divisor write that lands in the same cycle as a phase boundary, or one cycle before it, which decides whether the old or new count governs the next phase. The bench writes new divisors in the middle of a phase, at the last cycle of a phase and while idle, and lets a behavioural reference model decide which count applies at each boundary. A second collision, enable dropping on the last cycle of a phase, is provoked so that the would-be strobe must be suppressed; the outputs are compared with the model on every clock.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    localparam int FIELD_W = 8;
    localparam int DIV_W   = 2 * FIELD_W;
    localparam int CNT_W   = FIELD_W + 1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic [FIELD_W-1:0] hi;
        logic [FIELD_W-1:0] lo;
    } div_t;

    // low phase lasts count + 1 cycles
    function automatic logic [CNT_W-1:0] low_len(input div_t d);
        return {1'b0, d.lo} + CNT_W'(1);
    endfunction

    // high phase lasts count + 2 cycles
    function automatic logic [CNT_W-1:0] high_len(input div_t d);
        return {1'b0, d.hi} + CNT_W'(2);
    endfunction

endpackage

// File: rtl/scl_div_reg.sv
module scl_div_reg
    import scl_gen_pkg::*;
#(
    parameter logic [DIV_W-1:0] RESET_DIV = 16'h1F1F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [DIV_W-1:0] wdata,
    output div_t             div_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= div_t'(RESET_DIV);
        end else if (wr) begin
            div_q <= div_t'(wdata);
        end
    end

    // R1
    wr_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (div_q == div_t'($past(wdata))));

endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
    import scl_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             active,
    input  logic             restart,
    input  logic [CNT_W-1:0] new_len,
    output logic             first,
    output logic             last
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            len <= '0;
        end else if (!enable) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
            len <= new_len;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign first = active && (cnt == '0);
    assign last  = active && (cnt == len - CNT_W'(1));

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt < len));

    // R8
    cnt_parked_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> (cnt == '0));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   enable,
    input  logic   last,
    output phase_e phase,
    output logic   restart,
    output logic   pick_low
);

    phase_e nxt;

    always_comb begin
        nxt      = phase;
        restart  = 1'b0;
        pick_low = 1'b1;
        if (!enable) begin
            nxt = PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE: begin
                    nxt     = PH_LOW;
                    restart = 1'b1;
                end
                PH_LOW: if (last) begin
                    nxt      = PH_HIGH;
                    restart  = 1'b1;
                    pick_low = 1'b0;
                end
                PH_HIGH: if (last) begin
                    nxt     = PH_LOW;
                    restart = 1'b1;
                end
                default: nxt = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end

    // R5
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && enable) |=> (phase == PH_LOW));

    // R3
    low_to_high_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOW && last && enable) |=> (phase == PH_HIGH));

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_gen_pkg::*;
#(
    parameter logic [15:0] RESET_DIV = 16'h1F1F
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        div_wr,
    input  logic [15:0] div_wdata,
    input  logic        enable,
    output logic        scl_pull_low,
    output logic        fall_stb,
    output logic        rise_stb
);

    div_t             div_q;
    phase_e           phase;
    logic             restart;
    logic             pick_low;
    logic             first;
    logic             last;
    logic             active;
    logic [CNT_W-1:0] new_len;

    scl_div_reg #(.RESET_DIV(RESET_DIV)) u_div (
        .clk   (clk),
        .rst   (rst),
        .wr    (div_wr),
        .wdata (div_wdata),
        .div_q (div_q)
    );

    scl_phase_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .last     (last),
        .phase    (phase),
        .restart  (restart),
        .pick_low (pick_low)
    );

    assign active  = (phase != PH_IDLE);
    assign new_len = pick_low ? low_len(div_q) : high_len(div_q);

    scl_phase_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .active  (active),
        .restart (restart),
        .new_len (new_len),
        .first   (first),
        .last    (last)
    );

    assign scl_pull_low = (phase == PH_LOW);
    assign fall_stb     = first && (phase == PH_LOW);
    assign rise_stb     = first && (phase == PH_HIGH);

    // R6
    stb_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fall_stb, rise_stb}));

    // R6
    rise_released_chk: assert property (@(posedge clk) disable iff (rst)
        rise_stb |-> !scl_pull_low);

    // R8
    disable_release_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!scl_pull_low && !fall_stb && !rise_stb));

    // R6
    fall_single_chk: assert property (@(posedge clk) disable iff (rst)
        fall_stb |=> !fall_stb);

endmodule

// File: tb/scl_phase_gen_tb_top.sv
module scl_phase_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        div_wr = 1'b0;
    logic [15:0] div_wdata = 16'h0;
    logic        enable = 1'b0;
    logic        scl_pull_low, fall_stb, rise_stb;

    always #2 clk = ~clk;

    scl_phase_gen dut_i (
        .clk(clk), .rst(rst), .div_wr(div_wr), .div_wdata(div_wdata),
        .enable(enable), .scl_pull_low(scl_pull_low),
        .fall_stb(fall_stb), .rise_stb(rise_stb)
    );

    int    total = 0;
    int    bad = 0;
    string cur_req = "R4";

    // behavioural reference: 0 idle, 1 low, 2 high
    int m_ph, m_cnt, m_len, m_hi, m_lo;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_len = 0; m_hi = 'h1F; m_lo = 'h1F;
        end else begin
            if (!enable) begin
                m_ph = 0; m_cnt = 0;
            end else if (m_ph == 0) begin
                m_ph = 1; m_cnt = 0; m_len = m_lo + 1;
            end else if (m_cnt == m_len - 1) begin
                if (m_ph == 1) begin m_ph = 2; m_len = m_hi + 2; end
                else           begin m_ph = 1; m_len = m_lo + 1; end
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
            if (div_wr) begin
                m_hi = int'(div_wdata[15:8]);
                m_lo = int'(div_wdata[7:0]);
            end
        end
    end

    task automatic check(string req, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            check("R4", "reset pull_low", scl_pull_low, 1'b0);
            check("R4", "reset fall_stb", fall_stb, 1'b0);
            check("R4", "reset rise_stb", rise_stb, 1'b0);
        end else begin
            check(cur_req, "pull_low", scl_pull_low, m_ph == 1);
            check(cur_req, "fall_stb", fall_stb, m_ph == 1 && m_cnt == 0);
            check(cur_req, "rise_stb", rise_stb, m_ph == 2 && m_cnt == 0);
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_div(logic [15:0] v);
        @(negedge clk);
        div_wr = 1'b1; div_wdata = v;
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    task automatic wait_fall();
        @(negedge clk);
        while (!(m_ph == 1 && m_cnt == 0)) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    bit done = 0;
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        cycles(3);
        rst = 1'b0;
        // R4: default divisor, two full periods
        cur_req = "R4";
        enable = 1'b1;
        cycles(140);
        // R8: drop enable mid-phase, then restart
        cur_req = "R8";
        enable = 1'b0;
        cycles(5);
        // R1 R2 R3: program the 400 kHz setting while idle
        cur_req = "R1";
        wr_div(16'h1D21);
        cur_req = "R5";
        enable = 1'b1;
        cycles(4);
        cur_req = "R2";
        cycles(70);
        cur_req = "R3";
        cycles(70);
        // R9: minimum counts
        cur_req = "R9";
        wr_div(16'h0000);
        cycles(30);
        // R9: maximum counts
        wr_div(16'hFFFF);
        cycles(1100);
        // R7: write mid low phase, then right at a boundary
        cur_req = "R7";
        wr_div(16'h0A05);
        wait_fall();
        cycles(2);
        wr_div(16'h0302);
        cycles(40);
        wait_fall();
        cycles(1);
        div_wr = 1'b1; div_wdata = 16'h0601;   // lands on the low phase's last cycle (len 3)
        @(negedge clk);
        div_wr = 1'b0;
        cycles(40);
        // R8: enable falls on the last cycle of a low phase
        cur_req = "R8";
        wait_fall();
        cycles(1);
        enable = 1'b0;
        cycles(4);
        enable = 1'b1;
        cur_req = "R6";
        cycles(60);
        done = 1;
        finish_run();
    end

endmodule